// File: doc/BRIEF.md
# Polyline Vertex Stream Collector

This block takes a polyline draw command whose length is not given in advance and turns it into a stream of line segments. It pops words one at a time from a command FIFO. The first word is the head: one bit of it chooses flat or shaded mode, and its low 24 bits hold the colour of the first vertex. The block then spends a fixed setup time without popping. After that it collects vertices. A flat vertex is a single position word. A shaded vertex is a colour word followed by a position word. In shaded mode the first vertex takes its colour from the head, so its position word comes straight after the head.

Every vertex after the first produces one segment, from the previous vertex to the new one, carrying both endpoint colours. The block finds the end of the command from a sentinel word. It tests for the sentinel only in the slot where a new vertex group would begin, and only after two vertices have been collected. The sentinel is popped and thrown away. The block then signals completion and goes back to waiting for a head word. Rasterising the segments is left to a later stage.

Top module: `polyline_collector`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `seg_valid` is 0, `done` is 0, and `in_ready` is 1 so that a head word can be taken.
- R2: In idle, an offered word is popped as the head. Head bit 28 set selects shaded mode; head bits 23:0 are the colour of the first vertex. In flat mode every vertex uses that colour.
- R3: Once the head is popped, `in_ready` stays 0 for exactly SETUP_CYCLES clock cycles (16 by default). It then goes to 1.
- R4: In flat mode each word after the setup time is a vertex position: X is bits 10:0 and Y is bits 26:16, both 11-bit two's complement. Every vertex after the first yields a segment from the previous vertex to the new one. `seg_valid` is high for one cycle, in the cycle after the completing word is popped.
- R5: In shaded mode the first word after the setup time is the position of vertex 0. After that, words arrive in pairs: a colour word (bits 23:0), then a position word.
- R6: A word w is a terminator when (w & 32'hF000F000) == 32'h50005000. The test is made only on the first word of a vertex group: every word in flat mode, and only the colour slot in shaded mode. It applies only after two vertices have been collected. Before that, such a word is taken as ordinary vertex data.
- R7: A terminator is popped without producing a segment. `done` pulses for one cycle in the cycle after the pop, with `busy` already 0. The next word offered is taken as a new head.
- R8: While no word is offered, the block keeps its state and emits nothing. Collection resumes exactly where it stopped.
- R9: In shaded mode, a position word that matches the terminator pattern is taken as a position and does not end the polyline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A FIFO word is available |
| in_data | input | 32 | FIFO word at the head of the queue |
| in_ready | output | 1 | Pop strobe; a word is consumed when both valid and ready are high |
| seg_valid | output | 1 | A segment is present on the segment outputs this cycle |
| seg_x0 | output | 11 | Start X, signed |
| seg_y0 | output | 11 | Start Y, signed |
| seg_c0 | output | 24 | Start colour |
| seg_x1 | output | 11 | End X, signed |
| seg_y1 | output | 11 | End Y, signed |
| seg_c1 | output | 24 | End colour |
| busy | output | 1 | A polyline is in progress |
| done | output | 1 | One-cycle pulse when a terminator has closed the polyline |

## Verification
The assertions assume that `in_valid` and `in_data` follow a FIFO discipline. A word that is offered stays unchanged until it is popped. Every command starts with a well-formed head word. The bench drives its inputs on the falling edge and holds each word until `in_ready` has been seen high at a rising edge. It only offers head words when the block is idle. It inserts gaps only between whole words, never in the middle of one. Words that match the terminator pattern are placed on purpose in the slots that must ignore them.

// File: rtl/polyline_pkg.sv
`timescale 1ns/1ps
package polyline_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_GROUP = 2'd2,
    ST_POS   = 2'd3
  } pl_state_e;

  localparam logic [31:0] TERM_MASK  = 32'hF000_F000;
  localparam logic [31:0] TERM_VALUE = 32'h5000_5000;

  localparam int SHADE_BIT = 28;
  localparam int X_LSB     = 0;
  localparam int Y_LSB     = 16;

endpackage

// File: rtl/pl_word_decode.sv
`timescale 1ns/1ps
module pl_word_decode
  import polyline_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int COORD_W = 11,
  parameter int COLOR_W = 24
) (
  input  logic [WORD_W-1:0]  word,
  output logic               is_term,
  output logic               shade_sel,
  output logic [COORD_W-1:0] pos_x,
  output logic [COORD_W-1:0] pos_y,
  output logic [COLOR_W-1:0] color
);

  always_comb begin
    is_term   = ((word & TERM_MASK) == TERM_VALUE);
    shade_sel = word[SHADE_BIT];
    pos_x     = word[X_LSB +: COORD_W];
    pos_y     = word[Y_LSB +: COORD_W];
    color     = word[COLOR_W-1:0];
  end

endmodule

// File: rtl/pl_setup_timer.sv
`timescale 1ns/1ps
module pl_setup_timer #(
  parameter int SETUP_CYCLES = 16,
  localparam int CNT_W = (SETUP_CYCLES < 2) ? 1 : $clog2(SETUP_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(SETUP_CYCLES - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);

  AST_SETUP_RUNS_ON: assert property (@(posedge clk) disable iff (rst)
    (run && !expire) |=> run); // R3

endmodule

// File: rtl/pl_vertex_chain.sv
`timescale 1ns/1ps
module pl_vertex_chain #(
  parameter int COORD_W = 11,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               commit,
  input  logic [COORD_W-1:0] vx,
  input  logic [COORD_W-1:0] vy,
  input  logic [COLOR_W-1:0] vc,
  output logic               armed,
  output logic               seg_valid,
  output logic [COORD_W-1:0] seg_x0,
  output logic [COORD_W-1:0] seg_y0,
  output logic [COLOR_W-1:0] seg_c0,
  output logic [COORD_W-1:0] seg_x1,
  output logic [COORD_W-1:0] seg_y1,
  output logic [COLOR_W-1:0] seg_c1
);

  logic [1:0]         vcount;
  logic [COORD_W-1:0] prev_x, prev_y;
  logic [COLOR_W-1:0] prev_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcount    <= 2'd0;
      prev_x    <= '0;
      prev_y    <= '0;
      prev_c    <= '0;
      seg_valid <= 1'b0;
      seg_x0    <= '0;
      seg_y0    <= '0;
      seg_c0    <= '0;
      seg_x1    <= '0;
      seg_y1    <= '0;
      seg_c1    <= '0;
    end else begin
      seg_valid <= 1'b0;
      if (start) begin
        vcount <= 2'd0;
      end else if (commit) begin
        prev_x <= vx;
        prev_y <= vy;
        prev_c <= vc;
        if (vcount != 2'd2) vcount <= vcount + 2'd1;
        if (vcount != 2'd0) begin
          seg_valid <= 1'b1;
          seg_x0    <= prev_x;
          seg_y0    <= prev_y;
          seg_c0    <= prev_c;
          seg_x1    <= vx;
          seg_y1    <= vy;
          seg_c1    <= vc;
        end
      end
    end
  end

  assign armed = (vcount == 2'd2);

  AST_SEG_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> armed); // R4

  AST_SEG_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> $past(commit)); // R4

endmodule

// File: rtl/polyline_collector.sv
`timescale 1ns/1ps
module polyline_collector
  import polyline_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int COORD_W      = 11,
  parameter int COLOR_W      = 24,
  parameter int SETUP_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  output logic               in_ready,
  output logic               seg_valid,
  output logic [COORD_W-1:0] seg_x0,
  output logic [COORD_W-1:0] seg_y0,
  output logic [COLOR_W-1:0] seg_c0,
  output logic [COORD_W-1:0] seg_x1,
  output logic [COORD_W-1:0] seg_y1,
  output logic [COLOR_W-1:0] seg_c1,
  output logic               busy,
  output logic               done
);

  pl_state_e          state;
  logic               shaded;
  logic [COLOR_W-1:0] cur_color;

  logic               accept, term_hit, commit, head_take, expire, armed;
  logic               d_term, d_shade;
  logic [COORD_W-1:0] d_x, d_y;
  logic [COLOR_W-1:0] d_color;

  pl_word_decode #(.WORD_W(WORD_W), .COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_dec (
    .word(in_data), .is_term(d_term), .shade_sel(d_shade),
    .pos_x(d_x), .pos_y(d_y), .color(d_color)
  );

  assign in_ready  = (state != ST_SETUP);
  assign accept    = in_valid && in_ready;
  assign head_take = accept && (state == ST_IDLE);
  assign term_hit  = accept && (state == ST_GROUP) && armed && d_term;
  assign commit    = accept && ((state == ST_POS) ||
                     ((state == ST_GROUP) && !shaded && !(armed && d_term)));

  pl_setup_timer #(.SETUP_CYCLES(SETUP_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(head_take),
    .run(state == ST_SETUP), .expire(expire)
  );

  pl_vertex_chain #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_chain (
    .clk(clk), .rst(rst), .start(head_take), .commit(commit),
    .vx(d_x), .vy(d_y), .vc(cur_color), .armed(armed),
    .seg_valid(seg_valid), .seg_x0(seg_x0), .seg_y0(seg_y0), .seg_c0(seg_c0),
    .seg_x1(seg_x1), .seg_y1(seg_y1), .seg_c1(seg_c1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      shaded    <= 1'b0;
      cur_color <= '0;
      done      <= 1'b0;
    end else begin
      done <= term_hit;
      unique case (state)
        ST_IDLE: if (accept) begin
          shaded    <= d_shade;
          cur_color <= d_color;
          state     <= ST_SETUP;
        end
        ST_SETUP: if (expire) state <= shaded ? ST_POS : ST_GROUP;
        ST_GROUP: if (accept) begin
          if (armed && d_term) begin
            state <= ST_IDLE;
          end else if (shaded) begin
            cur_color <= d_color;
            state     <= ST_POS;
          end
        end
        ST_POS: if (accept) state <= ST_GROUP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && in_ready && !seg_valid)); // R7

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busy && !in_valid) |=> (!seg_valid && !done)); // R8

  AST_FLAT_ONE_COLOR: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !shaded) |-> (seg_c0 == seg_c1)); // R2

  AST_DONE_AFTER_TWO: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(armed)); // R6

endmodule

// File: tb/polyline_collector_tb.sv
`timescale 1ns/1ps
module polyline_collector_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, seg_valid, busy, done;
  logic [10:0] seg_x0, seg_y0, seg_x1, seg_y1;
  logic [23:0] seg_c0, seg_c1;

  int errors = 0;
  int checks = 0;

  logic [10:0] cap_x0 [0:15];
  logic [10:0] cap_y0 [0:15];
  logic [10:0] cap_x1 [0:15];
  logic [10:0] cap_y1 [0:15];
  logic [23:0] cap_c0 [0:15];
  logic [23:0] cap_c1 [0:15];
  int nseg = 0;
  int ndone = 0;

  always #5 clk = ~clk;

  polyline_collector dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .seg_valid(seg_valid),
    .seg_x0(seg_x0), .seg_y0(seg_y0), .seg_c0(seg_c0),
    .seg_x1(seg_x1), .seg_y1(seg_y1), .seg_c1(seg_c1),
    .busy(busy), .done(done)
  );

  always @(negedge clk) begin
    if (!rst && seg_valid && nseg < 16) begin
      cap_x0[nseg] = seg_x0; cap_y0[nseg] = seg_y0; cap_c0[nseg] = seg_c0;
      cap_x1[nseg] = seg_x1; cap_y1[nseg] = seg_y1; cap_c1[nseg] = seg_c1;
      nseg = nseg + 1;
    end
    if (!rst && done) ndone = ndone + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pos(input int x, input int y);
    logic [10:0] xx, yy;
    xx = x[10:0];
    yy = y[10:0];
    return {5'b0, yy, 5'b0, xx};
  endfunction

  task automatic push(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_seg(input int i, input string req, input int x0, input int y0,
                           input int c0, input int x1, input int y1, input int c1);
    chk(cap_x0[i] == x0[10:0] && cap_y0[i] == y0[10:0], req,
        {cap_x0[i], cap_y0[i]}, {x0[10:0], y0[10:0]});
    chk(cap_x1[i] == x1[10:0] && cap_y1[i] == y1[10:0], req,
        {cap_x1[i], cap_y1[i]}, {x1[10:0], y1[10:0]});
    chk(cap_c0[i] == c0[23:0] && cap_c1[i] == c1[23:0], req,
        {cap_c0[i], cap_c1[i]}, {c0[23:0], c1[23:0]});
  endtask

  task automatic start_run();
    nseg = 0;
    ndone = 0;
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(seg_valid == 1'b0 && done == 1'b0, "R1 outputs", {seg_valid, done}, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic test_flat();
    int lows;
    start_run();
    in_valid = 1'b1;
    in_data  = 32'h4800_ABCD;
    @(negedge clk);
    in_valid = 1'b0;
    lows = 0;
    while (!in_ready && lows < 100) begin
      lows++;
      @(negedge clk);
    end
    chk(lows == 16, "R3 setup length", lows, 16);
    chk(busy == 1'b1, "R2 busy after head", busy, 1);
    push(pos(1, 2));
    push(pos(-3, 4));
    push(pos(100, 200));
    push(32'h5A00_5123);
    chk(busy == 1'b0 && in_ready == 1'b1, "R7 idle after terminator", {busy, in_ready}, 2'b01);
    repeat (2) @(negedge clk);
    chk(nseg == 2, "R4 flat segment count", nseg, 2);
    check_seg(0, "R4 flat seg0", 1, 2, 24'h00ABCD, -3, 4, 24'h00ABCD);
    check_seg(1, "R4 flat seg1", -3, 4, 24'h00ABCD, 100, 200, 24'h00ABCD);
    chk(ndone == 1, "R7 done pulse", ndone, 1);
  endtask

  task automatic test_shaded();
    start_run();
    push(32'h5811_1111);
    push(pos(10, 10));
    push(32'h5022_5222);
    push(32'h5000_5000);
    push(32'h3033_3333);
    push(pos(7, 8));
    push(32'h5555_5555);
    repeat (2) @(negedge clk);
    chk(nseg == 2, "R5 R9 shaded segment count", nseg, 2);
    check_seg(0, "R5 R6 shaded seg0", 10, 10, 24'h111111, 0, 0, 24'h225222);
    check_seg(1, "R9 shaded seg1", 0, 0, 24'h225222, 7, 8, 24'h333333);
    chk(ndone == 1, "R7 shaded done", ndone, 1);
  endtask

  task automatic test_early_term();
    start_run();
    push(32'h4000_0777);
    push(32'h5000_5000);
    push(pos(5, 6));
    push(32'h5000_5000);
    repeat (2) @(negedge clk);
    chk(nseg == 1, "R6 early pattern is vertex", nseg, 1);
    check_seg(0, "R6 early seg", 0, 0, 24'h000777, 5, 6, 24'h000777);
    chk(ndone == 1 && busy == 1'b0, "R7 early done", {ndone[3:0], busy}, 5'b00010);
  endtask

  task automatic test_stall();
    start_run();
    push(32'h4000_0042);
    push(pos(1, 1));
    repeat (6) @(negedge clk);
    chk(nseg == 0 && busy == 1'b1 && in_ready == 1'b1, "R8 stall one vertex",
        {nseg[3:0], busy, in_ready}, 6'b000011);
    push(pos(2, 2));
    repeat (6) @(negedge clk);
    chk(nseg == 1 && ndone == 0, "R8 stall two vertices", {nseg[3:0], ndone[3:0]}, 8'h10);
    push(pos(3, 3));
    push(32'h5000_5000);
    repeat (2) @(negedge clk);
    chk(nseg == 2, "R8 resume count", nseg, 2);
    check_seg(1, "R8 resume seg", 2, 2, 24'h000042, 3, 3, 24'h000042);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_flat();
    test_shaded();
    test_early_term();
    test_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule